// File: doc/BRIEF.md
# Display Register Serial Access Engine

This block is a serial master that reaches the configuration registers of a small display controller over a four-wire SPI link. A host issues one command on a valid/ready port. The command carries an operation code, an 8-bit register address, 16-bit write data, a device-identifier bit and a transmit-invert flag. The engine breaks the operation into chip-select frames and encodes a start byte for each frame. It shifts the bytes out MSB first in SPI mode 3 and collects the bytes the slave returns.

When the operation finishes, the engine raises `done` for one cycle and presents the 16-bit result on `rdata`. The serial clock divider is derived from the system clock frequency, so register traffic never runs faster than the configured maximum serial rate.

Operation codes on `cmd_op`: 2'b00 sets the index, 2'b01 writes a register, 2'b10 reads a register, and 2'b11 reads status.

Top module: `dspi_reg_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 1, `cmd_ready` is 1, `done` is 0 and `rdata` is 0.
- R2: Every frame opens with a start byte whose bits 7..3 are 01110. Bit 2 is the device-identifier bit latched with the command. Bit 1 is the select bit: 0 for the index register, 1 for register data. Bit 0 is the direction bit: 0 for write, 1 for read.
- R3: Op 2'b00 sends one 3-byte frame: the start byte with select 0 and direction 0, then 0x00, then the register address.
- R4: Op 2'b01 sends the R3 frame, raises chip select, then sends a second 3-byte frame. That frame holds the start byte with select 1 and direction 0, then the data high byte, then the data low byte.
- R5: Op 2'b10 sends the R3 frame, then a second frame: the start byte with select 1 and direction 1, followed by two filler bytes. `rdata` is formed from the 2nd and 3rd bytes received in that frame, high byte first.
- R6: Op 2'b11 sends one 4-byte frame: the start byte with select 0 and direction 1, followed by three filler bytes. The 2nd received byte is discarded. `rdata` is formed from the 3rd and 4th received bytes, high byte first.
- R7: When `cmd_inv` is 1, every transmitted byte is bitwise complemented, filler bytes included.
- R8: Bytes are shifted MSB first in mode 3. `spi_sck` is high whenever `spi_cs_n` is high, and `spi_mosi` changes only while `spi_sck` is low within a frame.
- R9: Each high and low phase of `spi_sck` lasts at least ceil(SYS_HZ / (2*SCK_MAX_HZ)) clocks. With the defaults this is 25 clocks, giving 4 MHz from 200 MHz.
- R10: Between two frames, `spi_cs_n` stays high for at least two serial clock periods.
- R11: `cmd_ready` is high only while the engine is idle, and commands offered while busy are ignored. `done` is a one-cycle pulse. `rdata` is 0 after ops 2'b00 and 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted on valid |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 16 | Register write data |
| cmd_id | input | 1 | Device-identifier bit for the start byte |
| cmd_inv | input | 1 | Complement every transmitted byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read or status result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
A wrong byte or frame counter shows up at the next rising edge of `spi_cs_n` as a frame of the wrong length or content. It can also show as an extra or missing frame in the command's sequence, well before `done`. A divider or gap fault shows within one serial half-period as a phase shorter than the limit, and the bound checker flags it on the offending clock. Errors in the receive path only become visible at the `done` pulse. There the result must equal the exact bytes a bench slave returned, and for status the dummy byte must be excluded.

// File: rtl/dspi_reg_engine.sv
`timescale 1ns/1ps
module dspi_reg_engine #(
  parameter int SYS_HZ     = 200_000_000,
  parameter int SCK_MAX_HZ = 4_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic        cmd_id,
  input  logic        cmd_inv,
  output logic        done,
  output logic [15:0] rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = (SYS_HZ + 2*SCK_MAX_HZ - 1) / (2*SCK_MAX_HZ);
  localparam int DW   = $clog2(HALF + 1);
  localparam logic [1:0] OP_IX = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_ST = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_GAP} st_t;

  st_t         st;
  logic [1:0]  op_q;
  logic [7:0]  addr_q;
  logic [15:0] wd_q;
  logic        id_q, inv_q, frm;
  logic [1:0]  byt, gapc;
  logic [2:0]  bitc;
  logic [DW-1:0] div;
  logic [7:0]  sh;
  logic [15:0] rx;

  function automatic logic [7:0] pick(input logic [1:0] op, input logic [7:0] a,
                                      input logic [15:0] d, input logic id,
                                      input logic inv, input logic f, input logic [1:0] b);
    logic [7:0] v;
    v = 8'h00;
    if (!f) begin
      if (b == 2'd0)                 v = {5'b01110, id, 1'b0, op == OP_ST};
      else if (b == 2'd2 && op != OP_ST) v = a;
    end else begin
      if (b == 2'd0)                 v = {5'b01110, id, 1'b1, op == OP_RD};
      else if (op == OP_WR)          v = (b == 2'd1) ? d[15:8] : d[7:0];
    end
    return v ^ {8{inv}};
  endfunction

  wire       tick  = (div == DW'(HALF - 1));
  wire [1:0] lastb = (op_q == OP_ST) ? 2'd3 : 2'd2;
  wire       lastf = (op_q == OP_WR) || (op_q == OP_RD);

  assign cmd_ready = (st == S_IDLE);
  assign spi_mosi  = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_IX; addr_q <= '0; wd_q <= '0; id_q <= 1'b0; inv_q <= 1'b0;
      frm <= 1'b0; byt <= '0; gapc <= '0; bitc <= '0; div <= '0; sh <= '0; rx <= '0;
      spi_cs_n <= 1'b1; spi_sck <= 1'b1; done <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      div  <= (st == S_IDLE || tick) ? '0 : div + 1'b1;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op; addr_q <= cmd_addr; wd_q <= cmd_wdata;
          id_q <= cmd_id; inv_q <= cmd_inv;
          frm <= 1'b0; byt <= '0; bitc <= '0;
          sh <= pick(cmd_op, cmd_addr, cmd_wdata, cmd_id, cmd_inv, 1'b0, 2'd0);
          spi_cs_n <= 1'b0;
          st <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          spi_sck <= 1'b0;
          st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rx <= {rx[14:0], spi_miso};
          end else if (bitc != 3'd7) begin
            bitc <= bitc + 1'b1;
            sh <= {sh[6:0], 1'b0};
            spi_sck <= 1'b0;
          end else if (byt != lastb) begin
            byt <= byt + 1'b1;
            bitc <= '0;
            sh <= pick(op_q, addr_q, wd_q, id_q, inv_q, frm, byt + 1'b1);
            spi_sck <= 1'b0;
          end else begin
            spi_cs_n <= 1'b1;
            gapc <= '0;
            st <= S_GAP;
          end
        end
        S_GAP: if (tick) begin
          gapc <= gapc + 1'b1;
          if (gapc == 2'd3) begin
            if (frm != lastf) begin
              frm <= 1'b1; byt <= '0; bitc <= '0;
              sh <= pick(op_q, addr_q, wd_q, id_q, inv_q, 1'b1, 2'd0);
              spi_cs_n <= 1'b0;
              st <= S_LEAD;
            end else begin
              done <= 1'b1;
              rdata <= op_q[1] ? rx : 16'h0000;
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dspi_reg_engine_chk.sv
`timescale 1ns/1ps
module dspi_reg_engine_chk #(
  parameter int SYS_HZ     = 200_000_000,
  parameter int SCK_MAX_HZ = 4_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done
);
  localparam int HALF = (SYS_HZ + 2*SCK_MAX_HZ - 1) / (2*SCK_MAX_HZ);
  localparam int GAPC = 4 * HALF;
  localparam int RW   = $clog2(GAPC + 2);
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic sck_q, cs_q;
  logic [RW-1:0] run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1; cs_q <= 1'b1; run <= RW'(HALF); hi_run <= RW'(GAPC);
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (sck != sck_q) run <= RW'(1);
      else if (run != RMAX) run <= run + 1'b1;
      if (cs_n != cs_q) hi_run <= RW'(1);
      else if (hi_run != RMAX) hi_run <= hi_run + 1'b1;
    end
  end

  a_r8_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sck);
  a_r8_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(!cs_n) && $past(sck)) |-> $stable(mosi));
  a_r9_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != sck_q) |-> (run >= RW'(HALF)));
  a_r10_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_q) |-> (hi_run >= RW'(GAPC)));
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cmd_ready && cs_n));
endmodule

bind dspi_reg_engine dspi_reg_engine_chk #(.SYS_HZ(SYS_HZ), .SCK_MAX_HZ(SCK_MAX_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .done(done)
);

// File: tb/dspi_reg_engine_tb.sv
`timescale 1ns/1ps
module dspi_reg_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_id = 1'b0, cmd_inv = 1'b0, spi_miso = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_addr = 8'h00;
  logic [15:0] cmd_wdata = 16'h0000;
  logic cmd_ready, done, spi_cs_n, spi_sck, spi_mosi;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  dspi_reg_engine u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  int          exp_nb[$];
  logic [31:0] exp_fd[$];
  string       exp_tg[$];
  logic [15:0] exp_rd[$];
  string       rd_tg[$];

  logic [31:0] resp = 32'h0;
  logic [31:0] cap;
  int rcnt = 0;
  bit in_frame = 0, seen_rise = 0;
  realtime last_rise, last_cs_rise, min_per = 1.0e9, min_gap = 1.0e9;

  always @(negedge spi_cs_n) begin
    if (seen_rise && ($realtime - last_cs_rise) < min_gap) min_gap = $realtime - last_cs_rise;
    in_frame = 1; rcnt = 0; cap = 0;
    spi_miso <= resp[31];
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (rcnt > 0 && ($realtime - last_rise) < min_per) min_per = $realtime - last_rise;
    last_rise = $realtime;
    cap = {cap[30:0], spi_mosi};
    rcnt++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && rcnt > 0 && rcnt < 32) spi_miso <= resp[31 - rcnt];

  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0; seen_rise = 1; last_cs_rise = $realtime;
    chk(spi_sck === 1'b1, "R8", "sck high at frame end", {31'b0, spi_sck}, 32'h1);
    if (exp_nb.size() == 0) chk(0, "R11", "unexpected frame", cap, 32'h0);
    else begin
      int nb; logic [31:0] fd; string tg;
      nb = exp_nb.pop_front(); fd = exp_fd.pop_front(); tg = exp_tg.pop_front();
      chk(rcnt == nb, tg, "frame bit count", rcnt, nb);
      chk(cap == fd, tg, "frame bytes", cap, fd);
    end
  end

  logic done_d = 1'b0;
  always @(negedge clk) begin
    if (done && done_d) chk(0, "R11", "done longer than one cycle", 2, 1);
    done_d <= done;
    if (done) begin
      if (exp_rd.size() == 0) chk(0, "R11", "unexpected done", {16'h0, rdata}, 0);
      else begin
        logic [15:0] e; string tg;
        e = exp_rd.pop_front(); tg = rd_tg.pop_front();
        chk(rdata == e, tg, "rdata", {16'h0, rdata}, {16'h0, e});
      end
    end
  end

  function automatic logic [7:0] sb(input logic id, input logic rs, input logic rw);
    return 8'h70 | {5'b0, id, rs, rw};
  endfunction

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                        input logic id, input logic inv, input logic [31:0] rsp,
                        input string tg, input bit poke);
    logic [7:0] m;
    m = {8{inv}};
    resp = rsp;
    if (op != 2'd3) begin
      exp_nb.push_back(24); exp_fd.push_back({8'h00, sb(id,0,0)^m, m, a^m}); exp_tg.push_back(tg);
    end
    case (op)
      2'd1: begin exp_nb.push_back(24); exp_fd.push_back({8'h00, sb(id,1,0)^m, d[15:8]^m, d[7:0]^m}); exp_tg.push_back(tg); end
      2'd2: begin exp_nb.push_back(24); exp_fd.push_back({8'h00, sb(id,1,1)^m, m, m}); exp_tg.push_back(tg); end
      2'd3: begin exp_nb.push_back(32); exp_fd.push_back({sb(id,0,1)^m, m, m, m}); exp_tg.push_back(tg); end
      default: ;
    endcase
    exp_rd.push_back(op == 2'd2 ? rsp[23:8] : op == 2'd3 ? rsp[15:0] : 16'h0000);
    rd_tg.push_back(tg);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_id = id; cmd_inv = inv; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R11", "ready low after accept", {31'b0, cmd_ready}, 0);
    if (poke) begin
      bit rdy_seen;
      rdy_seen = 0;
      repeat (100) @(negedge clk);
      cmd_op = 2'd3; cmd_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (cmd_ready) rdy_seen = 1;
      end
      cmd_valid = 1'b0;
      chk(!rdy_seen, "R11", "ready while busy", {31'b0, rdy_seen}, 0);
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R11", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(spi_cs_n === 1'b1, "R1", "cs_n in reset", {31'b0, spi_cs_n}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1, "R1", "cs_n idle", {31'b0, spi_cs_n}, 1);
    chk(spi_sck === 1'b1, "R1", "sck idle", {31'b0, spi_sck}, 1);
    chk(cmd_ready === 1'b1, "R1", "ready idle", {31'b0, cmd_ready}, 1);
    chk(done === 1'b0, "R1", "done idle", {31'b0, done}, 0);
    chk(rdata === 16'h0, "R1", "rdata idle", {16'b0, rdata}, 0);

    do_cmd(2'd0, 8'h4F, 16'h0000, 1'b1, 1'b0, 32'h0, "R3", 0);
    do_cmd(2'd1, 8'h10, 16'h4240, 1'b0, 1'b0, 32'hFFFF_FFFF, "R4", 0);
    do_cmd(2'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 32'h5A92_2100, "R5", 0);
    do_cmd(2'd3, 8'h00, 16'h0000, 1'b1, 1'b0, 32'h33EE_C0DE, "R6", 0);
    do_cmd(2'd1, 8'h13, 16'h1319, 1'b1, 1'b1, 32'h0, "R7", 0);
    do_cmd(2'd2, 8'h45, 16'h0000, 1'b0, 1'b1, 32'hC3_8001_7E, "R7", 0);
    do_cmd(2'd3, 8'h00, 16'h0000, 1'b0, 1'b1, 32'h0155_AA0F, "R2", 0);
    do_cmd(2'd1, 8'hA5, 16'hBEEF, 1'b0, 1'b0, 32'h0, "R11", 1);
    repeat (400) @(negedge clk);

    chk(exp_nb.size() == 0, "R11", "frames outstanding", exp_nb.size(), 0);
    chk(exp_rd.size() == 0, "R11", "results outstanding", exp_rd.size(), 0);
    chk(min_per >= 250.0, "R9", "min sck period ns", int'(min_per), 250);
    chk(min_gap >= 500.0, "R10", "min cs high gap ns", int'(min_gap), 500);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule